// File: doc/BRIEF.md
# Dual-channel window watchdog supervisor

This block checks that two processors are each toggling their own watchdog line at a steady rate. It decides from those checks whether the actuator stages may be used. It runs on a fast system clock and does all of its timing on a one-cycle `tick` strobe, which is expected once per millisecond. Each line is synchronised and then shifted into a six-stage history register. A transition counts only when it has a clean level on both sides of it.

Each channel measures the time between its qualified edges against a window of 3 to 15 ticks. Measurement is done with a four-bit counter. When that counter reaches its terminal value, it restarts itself and marks the channel as late.

The block combines the state of both channels with a sticky fatal flag. From that it drives:
- an enable,
- a valve-relay allow,
- a motor-relay allow gated by a request input,
- a warning lamp and its inverted relay output.

The fatal flag is set when one line has been silent for a long time. Only the power-up reset clears it.

Top module: `dual_wd_supervisor`

## Requirements
- R1: While rst_n is low, and right after it, enable, valve_ok, motor_on, lamp_inv_on and fatal_err are 0 and lamp_on is 1.
- R2: A line transition takes effect on the third tick after it, provided the line held its old level for the three ticks before it and holds the new level for three ticks. A pulse lasting fewer than 3 ticks is ignored and does not disturb normal operation.
- R3: A channel becomes armed at its first qualified falling edge. A line that is low from reset therefore needs a rising and then a falling edge. enable goes high on the tick at which the later of the two channels is armed, and not before.
- R4: Qualified edges spaced 3 to 15 ticks apart, including exactly 3 and exactly 15, keep the outputs in normal operation.
- R5: With no qualified edge, a channel's counter restarts 16 ticks after its last edge and every 16 ticks after that. On an armed channel the first such restart puts the channel into violation on that tick.
- R6: A qualified edge that arrives fewer than 3 ticks after the channel's previous edge or counter restart is a violation.
- R7: When a qualified edge and a counter restart fall on the same tick, the restart wins: the channel is in violation even though the spacing alone would have been accepted.
- R8: While either channel is in violation or fatal_err is set, enable, valve_ok, motor_on and lamp_inv_on are 0 and lamp_on is 1. This holds even when only one channel has failed.
- R9: In normal operation valve_ok and enable are 1 and motor_on equals motor_req. lamp_req=1 gives lamp_on=0 and lamp_inv_on=1; lamp_req=0 gives lamp_on=1 and lamp_inv_on=0.
- R10: A qualified edge with spacing of 3 or more that does not coincide with a counter restart clears that channel's violation on its tick. Normal operation then returns if the other channel is fine and fatal_err is clear.
- R11: fatal_err goes to 1 on the 121st consecutive tick without a qualified edge on either channel. After that it stays 1, keeping the outputs faulted despite correct edges, until rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| tick | input | 1 | One-cycle logic time-base strobe (about 1 kHz) |
| wd_a | input | 1 | Watchdog line from the first processor |
| wd_b | input | 1 | Watchdog line from the second processor |
| motor_req | input | 1 | Motor relay request |
| lamp_req | input | 1 | Lamp request; high turns the lamp off and the lamp relay on |
| enable | output | 1 | System enable, high in normal operation |
| valve_ok | output | 1 | Valve relay allow |
| motor_on | output | 1 | Motor relay drive |
| lamp_on | output | 1 | Warning lamp drive |
| lamp_inv_on | output | 1 | Inverted lamp relay drive |
| fatal_err | output | 1 | Sticky fatal error flag |

## Verification
Every state register changes only on the clock edge that carries a tick, and the outputs are combinational from those registers and the request inputs. A line change made just after tick n therefore shows up at the outputs right after tick n+3, while a request change shows up before the next clock edge. The bench drives lines at the falling edge following a tick and queues each expectation against an absolute tick number, sampling at the falling edge after that tick. It probes the tick before each transition as well, to pin boundaries such as the 16-tick restart, the 15-tick spacing and the 121-tick fatal threshold to the exact tick.

// File: rtl/wds_pkg.sv
package wds_pkg;
  localparam int unsigned SYNC_STAGES  = 2;
  localparam int unsigned HIST_W       = 6;
  localparam int unsigned WIN_MIN      = 3;
  localparam int unsigned WIN_MAX      = 15;
  localparam int unsigned SILENT_LIMIT = 120;

  typedef struct packed {
    logic armed;
    logic viol;
    logic fatal_hit;
  } chan_state_t;
endpackage

// File: rtl/wds_sync.sv
module wds_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb ff_d = {ff_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/wds_edge.sv
module wds_edge #(
  parameter int unsigned HIST_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int unsigned HALF = HIST_W / 2;
  localparam logic [HIST_W-1:0] RISE_PAT = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [HIST_W-1:0] FALL_PAT = {{HALF{1'b1}}, {HALF{1'b0}}};

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_sh;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_sh = {hist_q[HIST_W-2:0], din};
    hist_d  = hist_q;
    if (tick) hist_d = hist_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign rise_stb = tick && (hist_sh == RISE_PAT);
  assign fall_stb = tick && (hist_sh == FALL_PAT);

  // R2: a qualified edge yields a single-cycle strobe, never two in a row
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb || fall_stb) |=> !(rise_stb || fall_stb));
  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
endmodule

// File: rtl/wds_window.sv
module wds_window
  import wds_pkg::*;
#(
  parameter int unsigned WMIN   = WIN_MIN,
  parameter int unsigned WMAX   = WIN_MAX,
  parameter int unsigned SILENT = SILENT_LIMIT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        rise_stb,
  input  logic        fall_stb,
  output chan_state_t st
);
  localparam int unsigned CW = $clog2(WMAX + 1);
  localparam int unsigned SW = $clog2(SILENT + 1);
  localparam logic [CW-1:0] CNT_TOP   = CW'(WMAX);
  localparam logic [CW-1:0] SHORT_LIM = CW'(WMIN - 1);
  localparam logic [SW-1:0] SIL_TOP   = SW'(SILENT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sil_q, sil_d;
  logic          armed_q, armed_d;
  logic          viol_q, viol_d;
  logic          edge_stb, restart;

  assign edge_stb = rise_stb || fall_stb;
  assign restart  = tick && (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d   = cnt_q;
    sil_d   = sil_q;
    armed_d = armed_q;
    viol_d  = viol_q;
    if (tick) begin
      if (restart) begin
        cnt_d = '0;
        if (armed_q) viol_d = 1'b1;
      end else if (edge_stb) begin
        cnt_d = '0;
        if (armed_q) viol_d = (cnt_q < SHORT_LIM);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (fall_stb) armed_d = 1'b1;
      if (edge_stb)               sil_d = '0;
      else if (sil_q != SIL_TOP)  sil_d = sil_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sil_q   <= '0;
      armed_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sil_q   <= sil_d;
      armed_q <= armed_d;
      viol_q  <= viol_d;
    end
  end

  assign st.armed     = armed_q;
  assign st.viol      = viol_q;
  assign st.fatal_hit = tick && !edge_stb && (sil_q == SIL_TOP);

  // R3: once armed, a channel stays armed
  assert_armed_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R5: violations only begin on a tick and only on an armed channel
  assert_viol_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_q) |-> ($past(tick) && $past(armed_q)));
  // R10: a violation only clears on a tick that carried an edge
  assert_viol_clear_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(viol_q) |-> $past(edge_stb));
  // R11: the silence counter saturates at its limit
  assert_silence_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sil_q <= SIL_TOP);
endmodule

// File: rtl/dual_wd_supervisor.sv
module dual_wd_supervisor
  import wds_pkg::*;
#(
  parameter int unsigned N_SYNC = SYNC_STAGES,
  parameter int unsigned H_W    = HIST_W,
  parameter int unsigned W_MIN  = WIN_MIN,
  parameter int unsigned W_MAX  = WIN_MAX,
  parameter int unsigned SILENT = SILENT_LIMIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wd_a,
  input  logic wd_b,
  input  logic motor_req,
  input  logic lamp_req,
  output logic enable,
  output logic valve_ok,
  output logic motor_on,
  output logic lamp_on,
  output logic lamp_inv_on,
  output logic fatal_err
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0] wd_raw;
  logic [NCH-1:0] wd_s, rise, fall, armed, viol, hit;
  chan_state_t    st [NCH];
  logic           fatal_q, fatal_d, run_ok;

  assign wd_raw = {wd_b, wd_a};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wds_sync #(.STAGES(N_SYNC)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(wd_raw[g]), .dout(wd_s[g]));
    wds_edge #(.HIST_W(H_W)) i_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick), .din(wd_s[g]),
      .rise_stb(rise[g]), .fall_stb(fall[g]));
    wds_window #(.WMIN(W_MIN), .WMAX(W_MAX), .SILENT(SILENT)) i_win (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .rise_stb(rise[g]), .fall_stb(fall[g]), .st(st[g]));
    assign armed[g] = st[g].armed;
    assign viol[g]  = st[g].viol;
    assign hit[g]   = st[g].fatal_hit;
  end

  always_comb fatal_d = fatal_q || (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fatal_q <= 1'b0;
    else        fatal_q <= fatal_d;
  end

  assign run_ok      = (&armed) && !(|viol) && !fatal_q;
  assign enable      = run_ok;
  assign valve_ok    = run_ok;
  assign motor_on    = run_ok && motor_req;
  assign lamp_on     = !run_ok || !lamp_req;
  assign lamp_inv_on = run_ok && lamp_req;
  assign fatal_err   = fatal_q;

  // R11: the fatal flag never clears without reset
  assert_fatal_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> fatal_err);
  // R8: whenever enable is low every actuator output is in its safe state
  assert_safe_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!valve_ok && !motor_on && !lamp_inv_on && lamp_on));
  // R9: lamp and inverted lamp are never on together
  assert_lamp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lamp_on && lamp_inv_on));
  // R11: enable is never high while the fatal flag is set
  assert_enable_not_fatal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> !fatal_err);
endmodule

// File: tb/test_dual_wd_supervisor.sv
module test_dual_wd_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wd_a = 1'b0, wd_b = 1'b0, motor_req = 1'b0, lamp_req = 1'b0;
  logic enable, valve_ok, motor_on, lamp_on, lamp_inv_on, fatal_err;

  dual_wd_supervisor i_dual_wd_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_a(wd_a), .wd_b(wd_b),
    .motor_req(motor_req), .lamp_req(lamp_req), .enable(enable),
    .valve_ok(valve_ok), .motor_on(motor_on), .lamp_on(lamp_on),
    .lamp_inv_on(lamp_inv_on), .fatal_err(fatal_err));

  always #10 clk = ~clk;

  int divc = 0;
  int tnum = 0;
  int base = 0;
  always @(negedge clk) begin
    divc <= (divc == 3) ? 0 : divc + 1;
    tick <= (divc == 3);
  end
  always @(posedge clk) if (tick) tnum <= tnum + 1;

  typedef struct {
    logic [5:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];
  event chk_ev;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic exp_fatal = 1'b0;

  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [5:0] act;
        e = q.pop_front();
        act = {enable, valve_ok, motor_on, lamp_on, lamp_inv_on, fatal_err};
        compared++;
        if (act !== e.v) begin
          mismatched++;
          $display("FAIL %s: got en/vo/mo/la/li/fa=%b expected %b", e.tag, act, e.v);
        end
      end
    end
  end

  task automatic push(logic [5:0] v, string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
    ->chk_ev;
    #2;
  endtask

  task automatic expect_state(bit ok, string tag);
    push({ok, ok, ok & motor_req, ~ok | ~lamp_req, ok & lamp_req, exp_fatal}, tag);
  endtask

  task automatic at(int n);
    while (tnum < base + n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push(6'b000100, "R1 state during reset");
    rst_n = 1'b1;
    base = tnum;
    push(6'b000100, "R1 state after reset release");
    at(1);  wd_a = 1; wd_b = 1;
    at(11); expect_state(0, "R3 rising edge alone does not enable");
    wd_a = 0; wd_b = 0;
    at(13); expect_state(0, "R3 enable not before falling edge tick");
    at(14); expect_state(1, "R3 enable on first falling edge");
    motor_req = 1; @(negedge clk);
    expect_state(1, "R9 motor follows request high");
    lamp_req = 1; @(negedge clk);
    expect_state(1, "R9 lamp request high swaps lamp outputs");
    at(15); wd_a = 1;
    at(17); wd_a = 0;
    at(21); expect_state(1, "R2 two-tick pulse ignored");
    wd_a = 1; wd_b = 1;
    at(24); expect_state(1, "R2 clean edge after glitch accepted");
    at(36); wd_a = 0; wd_b = 0;
    at(38); expect_state(1, "R4 before 15-tick edge");
    at(39); expect_state(1, "R4 spacing of 15 accepted");
    wd_a = 1; wd_b = 1;
    at(42); expect_state(1, "R4 spacing of 3 accepted");
    at(57); expect_state(1, "R5 no restart before 16 ticks");
    at(58); expect_state(0, "R5 restart 16 ticks after edge faults");
    at(72); wd_a = 0; wd_b = 0;
    at(75); expect_state(0, "R6 edge 1 tick after restart is short");
    at(88); wd_a = 1; wd_b = 1;
    at(91); expect_state(0, "R7 restart dominates coincident edge");
    at(94); wd_a = 0; wd_b = 0;
    at(96); expect_state(0, "R10 still faulted before recovery edge");
    at(97); expect_state(1, "R10 in-window edge restores operation");
    at(104); wd_a = 1;
    at(113); expect_state(0, "R8 single silent channel faults outputs");
    for (int k = 114; k <= 214; k += 10) begin
      at(k);
      wd_a = ~wd_a;
    end
    at(217); expect_state(0, "R11 fatal not yet on 120th silent tick");
    at(218); exp_fatal = 1;
    expect_state(0, "R11 fatal on 121st silent tick");
    at(224); wd_a = ~wd_a; wd_b = 1;
    at(234); wd_a = ~wd_a; wd_b = 0;
    at(237); expect_state(0, "R11 fatal keeps outputs faulted");
    rst_n = 0; exp_fatal = 0;
    @(negedge clk);
    push(6'b000100, "R11 reset clears fatal flag");
    rst_n = 1;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule